// File: doc/BRIEF.md
# Indirect Pointer Address Generator

This block turns an indirect load or store request into a data-memory address and a pair of two-cycle memory strobes. It keeps its own copy of three 16-bit pointers (X, Y, Z) and, per request, uses one of them in one of four addressing modes: plain, post-increment, pre-decrement, or base plus an unsigned 6-bit offset. After the access it hands back the updated pointer value for the register file to record. It also commits that value to its own copy.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the request fields steady. `req_ready` is low only during the first cycle of an access. A new request can therefore be taken in the second cycle of the current one, which sustains one access every two cycles. The general register file keeps the block's pointer copy current through a plain load port (`ptr_ld_*`). That port is never back-pressured.

Encodings: pointer select 0 = X, 1 = Y, 2 = Z, 3 = reserved. Mode 0 = plain, 1 = post-increment, 2 = pre-decrement, 3 = displacement.

Top module: `ptr_agu`

## Requirements
- R1: `req_ready` is high in idle and in the second access cycle, and low in the first access cycle. A request is taken when `req_valid` and `req_ready` are high at a rising edge.
- R2: Plain mode (mode 0) drives the selected pointer as `mem_addr` and does not write the pointer back (`wb_en` stays 0).
- R3: Post-increment mode (mode 1) drives the old pointer as `mem_addr`. When `done` is high it raises `wb_en` with `wb_val` = old pointer + 1.
- R4: Pre-decrement mode (mode 2) drives old pointer - 1 as `mem_addr`. When `done` is high it raises `wb_en` with `wb_val` equal to that same decremented value.
- R5: Displacement mode (mode 3) with Y or Z drives pointer + zero-extended `req_disp` (0..63) as `mem_addr` and does not write the pointer back.
- R6: All pointer and address arithmetic wraps modulo 2^16.
- R7: Displacement mode with X, or pointer select 3, is illegal. Such a request completes in the same two cycles, with `err` high alongside `done` and with no `mem_rd`, `mem_wr` or `wb_en`.
- R8: A legal access raises `mem_rd` (load) or `mem_wr` (store) for exactly the two cycles after acceptance, with `mem_addr` held steady. `done` is high in the second of those cycles.
- R9: `wb_en`, `wb_sel` and `wb_val` are valid only together with `done`. The pointer copy takes the new value at the end of that cycle. A request accepted in that same cycle already uses the new value.
- R10: When `ptr_ld_en` is high, the selected pointer takes `ptr_ld_val` at the clock edge, and a select of 3 is ignored. This load overrides a write-back to the same pointer in the same cycle. A request accepted in that cycle sees the loaded value.
- R11: After reset all three pointers are 0, the block is idle with `req_ready` high, and `mem_rd`, `mem_wr`, `done`, `wb_en` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 reserved |
| req_mode | input | 2 | Mode: 0 plain, 1 post-inc, 2 pre-dec, 3 displacement |
| req_disp | input | 6 | Unsigned displacement, used in mode 3 |
| req_store | input | 1 | 1 = store, 0 = load |
| ptr_ld_en | input | 1 | Load a pointer copy this cycle |
| ptr_ld_sel | input | 2 | Pointer to load (3 ignored) |
| ptr_ld_val | input | 16 | Value to load |
| mem_addr | output | 16 | Data-memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wb_en | output | 1 | Pointer write-back valid |
| wb_sel | output | 2 | Pointer being written back |
| wb_val | output | 16 | Updated pointer value |
| done | output | 1 | Last cycle of an access |
| err | output | 1 | Illegal request, valid with done |

## Verification
The bound assertions check the rules that hold on every cycle without any knowledge of pointer contents. These are: the read and write strobes never overlap, and a strobe lasts its two cycles with a steady address. The handshake closes after acceptance and reopens with `done`. Write-back appears only with `done`. An illegal request stays silent on the memory side. The address arithmetic of each mode, the wrap at 0 and 0xFFFF, the forwarding of a write-back into the next request, and the priority of an external pointer load over a write-back all depend on stored pointer values. Those can only be shown by the bench's reference model, which tracks the pointers through directed and random request streams.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [1:0] {
    PSEL_X   = 2'd0,
    PSEL_Y   = 2'd1,
    PSEL_Z   = 2'd2,
    PSEL_RSV = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_PH1  = 2'd1,
    SQ_PH2  = 2'd2
  } seq_e;

endpackage

// File: rtl/ptr_agu_bank.sv
module ptr_agu_bank #(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              wb_en,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [ADDR_W-1:0] wb_val,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_val
);

  localparam int FLAT_W = NUM_PTR * ADDR_W;

  // Next-state view of every pointer: external load beats write-back.
  logic [FLAT_W-1:0] nxt_flat;
  logic [FLAT_W-1:0] cur_flat;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic ld_hit;
    logic wb_hit;
    assign ld_hit = ld_en && (ld_sel == SEL_W'(g));
    assign wb_hit = wb_en && (wb_sel == SEL_W'(g));
    assign nxt_flat[g*ADDR_W +: ADDR_W] =
      ld_hit ? ld_val : (wb_hit ? wb_val : cur_flat[g*ADDR_W +: ADDR_W]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_flat[g*ADDR_W +: ADDR_W] <= '0;
      else        cur_flat[g*ADDR_W +: ADDR_W] <= nxt_flat[g*ADDR_W +: ADDR_W];
    end
  end

  // Read returns the forwarded value so a request sees same-cycle updates.
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (int'(rd_sel) == i) rd_val = nxt_flat[i*ADDR_W +: ADDR_W];
    end
  end

endmodule

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
  import ptr_agu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wb_val,
  output logic              wb_need,
  output logic              illegal
);

  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] inc_v;
  logic [ADDR_W-1:0] dec_v;
  logic [ADDR_W-1:0] off_v;

  assign disp_ext = {{PAD_W{1'b0}}, disp};
  assign inc_v    = base + ADDR_W'(1);
  assign dec_v    = base - ADDR_W'(1);
  assign off_v    = base + disp_ext;

  always_comb begin
    illegal = (int'(sel) >= NUM_PTR) ||
              ((amode_e'(mode) == AM_DISP) && (sel == SEL_W'(PSEL_X)));
    addr    = base;
    wb_val  = base;
    wb_need = 1'b0;
    case (amode_e'(mode))
      AM_POSTINC: begin
        wb_val  = inc_v;
        wb_need = 1'b1;
      end
      AM_PREDEC: begin
        addr    = dec_v;
        wb_val  = dec_v;
        wb_need = 1'b1;
      end
      AM_DISP: addr = off_v;
      default: ;
    endcase
    if (illegal) wb_need = 1'b0;
  end

endmodule

// File: rtl/ptr_agu_seq.sv
module ptr_agu_seq
  import ptr_agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [ADDR_W-1:0] c_wb_val,
  input  logic              c_wb_need,
  input  logic              c_illegal,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              done,
  output logic              err,
  output logic              wb_en,
  output logic [SEL_W-1:0]  wb_sel,
  output logic [ADDR_W-1:0] wb_val
);

  seq_e              state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wbv_q;
  logic [SEL_W-1:0]  sel_q;
  logic              need_q;
  logic              store_q;
  logic              err_q;
  logic              accept;
  logic              active;

  assign req_ready = (state_q != SQ_PH1);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      wbv_q   <= '0;
      sel_q   <= '0;
      need_q  <= 1'b0;
      store_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) begin
        state_q <= SQ_PH1;
        addr_q  <= c_addr;
        wbv_q   <= c_wb_val;
        sel_q   <= req_sel;
        need_q  <= c_wb_need;
        store_q <= req_store;
        err_q   <= c_illegal;
      end else if (state_q == SQ_PH1) begin
        state_q <= SQ_PH2;
      end else begin
        state_q <= SQ_IDLE;
      end
    end
  end

  assign active   = (state_q != SQ_IDLE);
  assign mem_addr = addr_q;
  assign mem_rd   = active && !store_q && !err_q;
  assign mem_wr   = active &&  store_q && !err_q;
  assign done     = (state_q == SQ_PH2);
  assign err      = done && err_q;
  assign wb_en    = done && need_q;
  assign wb_sel   = sel_q;
  assign wb_val   = wbv_q;

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int NUM_PTR = 3,
  localparam int SEL_W  = $clog2(NUM_PTR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_ptr,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic              req_store,
  input  logic              ptr_ld_en,
  input  logic [SEL_W-1:0]  ptr_ld_sel,
  input  logic [ADDR_W-1:0] ptr_ld_val,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              wb_en,
  output logic [SEL_W-1:0]  wb_sel,
  output logic [ADDR_W-1:0] wb_val,
  output logic              done,
  output logic              err
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] c_addr;
  logic [ADDR_W-1:0] c_wbv;
  logic              c_need;
  logic              c_ill;

  ptr_agu_bank #(.ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ptr_ld_en),
    .ld_sel (ptr_ld_sel),
    .ld_val (ptr_ld_val),
    .wb_en  (wb_en),
    .wb_sel (wb_sel),
    .wb_val (wb_val),
    .rd_sel (req_ptr),
    .rd_val (base)
  );

  ptr_agu_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) u_calc (
    .base    (base),
    .sel     (req_ptr),
    .mode    (req_mode),
    .disp    (req_disp),
    .addr    (c_addr),
    .wb_val  (c_wbv),
    .wb_need (c_need),
    .illegal (c_ill)
  );

  ptr_agu_seq #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_store (req_store),
    .req_sel   (req_ptr),
    .c_addr    (c_addr),
    .c_wb_val  (c_wbv),
    .c_wb_need (c_need),
    .c_illegal (c_ill),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .err       (err),
    .wb_en     (wb_en),
    .wb_sel    (wb_sel),
    .wb_val    (wb_val)
  );

endmodule

// File: rtl/ptr_agu_chk.sv
module ptr_agu_chk #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEL_W-1:0]  req_ptr,
  input logic [1:0]        req_mode,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              wb_en,
  input logic              done,
  input logic              err
);

  logic acc;
  assign acc = req_valid && req_ready;

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_close_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  p_done_reopens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_second_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !done) |=> (done && $stable(mem_addr) &&
                                       ($past(mem_rd) == mem_rd) && ($past(mem_wr) == mem_wr)));

  p_wb_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !mem_rd && !mem_wr && !wb_en));

  p_x_disp_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_ptr == '0 && req_mode == 2'd3) |=> (!mem_rd && !mem_wr));

endmodule

bind ptr_agu ptr_agu_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_ptr_agu.sv
`timescale 1ns/1ps
module tb_ptr_agu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_ptr = '0;
  logic [1:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic        req_store = 1'b0;
  logic        ptr_ld_en = 1'b0;
  logic [1:0]  ptr_ld_sel = '0;
  logic [15:0] ptr_ld_val = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, wb_en, done, err;
  logic [1:0]  wb_sel;
  logic [15:0] wb_val;

  always #2.5 clk = ~clk;

  ptr_agu dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit finished = 0;

  // Reference model state
  int        ph = 0;
  bit [15:0] ptr [3] = '{16'h0, 16'h0, 16'h0};
  bit [15:0] m_addr, m_wbv;
  bit        m_need, m_st, m_err, m_wrap, m_acc_last;
  int        m_mode, m_sel;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [15:0] nx [3];
    bit [15:0] base;
    bit acc;
    if (!rst_n) begin
      ph = 0; ptr = '{16'h0, 16'h0, 16'h0}; m_acc_last = 0;
    end else begin
      started = 1;
      nx = ptr;
      if (ph == 2 && m_need && !m_err) nx[m_sel] = m_wbv;
      if (ptr_ld_en && ptr_ld_sel < 3) nx[ptr_ld_sel] = ptr_ld_val;
      acc = req_valid && (ph != 1);
      if (acc) begin
        base   = (req_ptr < 3) ? nx[req_ptr] : 16'h0;
        m_mode = req_mode; m_sel = req_ptr; m_st = req_store;
        m_err  = (req_ptr == 3) || (req_mode == 3 && req_ptr == 0);
        m_need = 0; m_wrap = 0; m_addr = base; m_wbv = base;
        case (req_mode)
          1: begin m_wbv = base + 16'd1; m_need = 1; m_wrap = (base == 16'hFFFF); end
          2: begin m_addr = base - 16'd1; m_wbv = m_addr; m_need = 1; m_wrap = (base == 16'h0); end
          3: begin m_addr = base + 16'(req_disp); m_wrap = (int'(base) + int'(req_disp) > 65535); end
          default: ;
        endcase
        if (m_err) m_need = 0;
        ph = 1;
      end else if (ph == 1) ph = 2;
      else ph = 0;
      ptr = nx;
      m_acc_last = acc;
    end
  end

  // Compare every cycle away from the edge
  always @(negedge clk) begin
    if (started && rst_n) begin
      string atag;
      bit act_strobe;
      atag = m_wrap ? "R6" : (m_mode == 0 ? "R2" : m_mode == 1 ? "R3" : m_mode == 2 ? "R4" : "R5");
      act_strobe = (ph != 0) && !m_err;
      chk(req_ready === (ph != 1), "R1", "req_ready", req_ready, ph != 1);
      chk(mem_rd === (act_strobe && !m_st), m_err ? "R7" : "R8", "mem_rd", mem_rd, act_strobe && !m_st);
      chk(mem_wr === (act_strobe && m_st),  m_err ? "R7" : "R8", "mem_wr", mem_wr, act_strobe && m_st);
      chk(done === (ph == 2), "R8", "done", done, ph == 2);
      chk(err === (ph == 2 && m_err), "R7", "err", err, ph == 2 && m_err);
      chk(wb_en === (ph == 2 && m_need), "R9", "wb_en", wb_en, ph == 2 && m_need);
      if (act_strobe)
        chk(mem_addr === m_addr, atag, "mem_addr", mem_addr, m_addr);
      if (ph == 2 && m_need) begin
        chk(wb_val === m_wbv, atag, "wb_val", wb_val, m_wbv);
        chk(wb_sel === 2'(m_sel), "R9", "wb_sel", wb_sel, m_sel);
      end
    end
  end

  task automatic issue(input int sel, input int mode, input int disp, input bit st);
    req_ptr = 2'(sel); req_mode = 2'(mode); req_disp = 6'(disp); req_store = st;
    req_valid = 1'b1;
    do begin @(posedge clk); #1; end while (!m_acc_last);
    req_valid = 1'b0;
  endtask

  task automatic load_ptr(input int sel, input int val);
    ptr_ld_en = 1'b1; ptr_ld_sel = 2'(sel); ptr_ld_val = 16'(val);
    @(posedge clk); #1;
    ptr_ld_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_rd === 1'b0 && mem_wr === 1'b0 && done === 1'b0 &&
        wb_en === 1'b0 && err === 1'b0, "R11", "reset outputs", {req_ready, mem_rd, mem_wr, done, wb_en, err}, 6'b100000);
    rst_n = 1'b1;
    idle(2);
    // R11: pointers reset to zero
    issue(2, 0, 0, 0);
    chk(mem_addr === 16'h0, "R11", "Z after reset", mem_addr, 0);
    idle(2);
    // R2..R5 with each pointer, loads and stores
    load_ptr(0, 16'h1000); load_ptr(1, 16'h2000); load_ptr(2, 16'h3000);
    issue(0, 0, 0, 0); issue(0, 1, 0, 1); issue(0, 2, 0, 0);
    issue(1, 1, 0, 0); issue(1, 3, 63, 1); issue(1, 2, 0, 1);
    issue(2, 3, 0, 0); issue(2, 3, 63, 0); issue(2, 1, 0, 1);
    idle(3);
    // R7 illegal requests
    issue(0, 3, 5, 0); issue(3, 1, 0, 1); issue(0, 3, 63, 1);
    idle(3);
    // R6 wrap cases
    load_ptr(0, 16'h0000); load_ptr(1, 16'hFFFF); load_ptr(2, 16'hFFF0);
    issue(0, 2, 0, 0); issue(1, 1, 0, 0); issue(2, 3, 63, 1);
    idle(3);
    issue(0, 0, 0, 0);
    chk(mem_addr === 16'hFFFF, "R6", "X after pre-dec wrap", mem_addr, 16'hFFFF);
    issue(1, 0, 0, 0);
    chk(mem_addr === 16'h0000, "R6", "Y after post-inc wrap", mem_addr, 0);
    idle(3);
    // R9 back-to-back forwarding of write-back
    load_ptr(1, 16'h0100);
    issue(1, 1, 0, 0); issue(1, 1, 0, 0); issue(1, 1, 0, 0);
    chk(mem_addr === 16'h0102, "R9", "forwarded post-inc", mem_addr, 16'h0102);
    idle(3);
    // R10 external load beats same-cycle write-back
    load_ptr(0, 16'h0500);
    issue(0, 1, 0, 0);
    @(posedge clk); #1;
    ptr_ld_en = 1'b1; ptr_ld_sel = 2'd0; ptr_ld_val = 16'h0ABC;
    @(posedge clk); #1;
    ptr_ld_en = 1'b0;
    idle(2);
    issue(0, 0, 0, 0);
    chk(mem_addr === 16'h0ABC, "R10", "load over write-back", mem_addr, 16'h0ABC);
    idle(3);
    // R10 load in the acceptance cycle, and reserved select ignored
    ptr_ld_en = 1'b1; ptr_ld_sel = 2'd2; ptr_ld_val = 16'h4444;
    issue(2, 0, 0, 0);
    ptr_ld_en = 1'b0;
    chk(mem_addr === 16'h4444, "R10", "same-cycle load seen", mem_addr, 16'h4444);
    idle(2);
    load_ptr(3, 16'h9999);
    issue(2, 0, 0, 0);
    chk(mem_addr === 16'h4444, "R10", "reserved load ignored", mem_addr, 16'h4444);
    idle(3);
    // Random stream, model compared every cycle
    for (int k = 0; k < 400; k++) begin
      ptr_ld_en  = ($urandom % 5 == 0);
      ptr_ld_sel = 2'($urandom);
      ptr_ld_val = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
      issue($urandom % 4, $urandom % 4, $urandom % 64, 1'($urandom));
      ptr_ld_en = 1'b0;
      if ($urandom % 3 == 0) idle($urandom % 3);
    end
    idle(4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule